// File: doc/BRIEF.md
# Binary-Pixel Table-Lookup Gaussian Smoother

This block smooths a raster stream of 8-bit grayscale pixels with a 3x3 Gaussian kernel whose vertical and horizontal taps are both 1, 2, 1 (total weight 16). Each incoming pixel is first reduced to a single bit by comparing it with a programmable threshold. Because every smoothed sample is a weighted count of one-bit pixels, the datapath has no multipliers.

Two one-bit line memories, each one image row long, hold the two rows above the current one. For every accepted pixel, the bit from two rows up, the bit from one row up and the new bit form a 3-bit code. That code indexes an eight-entry table that returns the column's vertical weighted sum. The table values for three consecutive columns are then combined with weights 1, 2, 1 using shifts and adds. The result is an integer from 0 to 16 that stands for the smoothed value times 1/16.

Outputs appear only for centre pixels whose full 3x3 neighbourhood lies inside the frame. The first two rows of a frame and the first two columns of each row therefore produce no output. The block is intended as the smoothing stage in front of a feature detector. A second instance with a wider kernel can be placed next to it to form a difference of two scales.

Top module: `bin_gauss_filter`

## Requirements
- R1: A pixel becomes 1 when its value is strictly greater than the threshold, and 0 otherwise, including when it equals the threshold. The threshold register resets to 128.
- R2: When `thrWrEn` is high at a clock edge, `thrWrData` becomes the threshold. Pixels sampled on later edges use the new value.
- R3: For the accepted input pixel at row r, column c (both counted from 0) with r >= 2 and c >= 2, the block emits exactly one output for the centre at (r-1, c-1). No input in rows 0 and 1 of a frame, or in columns 0 and 1 of a line, produces an output.
- R4: `outPix` equals the sum over the 3x3 window of wv*wh*bit, where wv and wh are 1, 2, 1 from top to bottom and from left to right. The field is 5 bits wide and unsigned.
- R5: `outPix` never exceeds 16. An all-white window gives 16 and an all-black window gives 0.
- R6: When a pixel is sampled at edge k, `outValid` is high only in the cycle after edge k+1, as a one-cycle pulse per output.
- R7: `frameStart` (qualified by `pixValid`) marks row 0, column 0. `lineStart` marks column 0 of the next row. Cycles with `pixValid` low change nothing, so idle gaps leave the output sequence unchanged.
- R8: The output sequence is in raster order of the centre pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| thrWrEn | input | 1 | Threshold write strobe |
| thrWrData | input | 8 | New threshold value |
| pixValid | input | 1 | Input pixel valid |
| pixIn | input | 8 | Grayscale input pixel |
| lineStart | input | 1 | First pixel of a line |
| frameStart | input | 1 | First pixel of a frame |
| outValid | output | 1 | Smoothed pixel valid |
| outPix | output | 5 | Smoothed pixel, 0..16 in units of 1/16 |

## Verification
A line memory written at the wrong column, or a shift of the column-sum history on an idle cycle, shows up as a wrong `outPix` value. The error appears at the first interior pixel of the row after the fault, or of the same row when the history is at fault. A row or column counter that is off by one either adds or drops an output pulse at a line boundary, or shifts the whole output pattern by one position; both show up in the raster-ordered comparison within one line. A threshold comparison that is off by one shows only on pixel values equal to the threshold, so frames built from exactly those values are used.

// File: rtl/bgf_pkg.sv
package bgf_pkg;
  localparam int PIX_W  = 8;
  localparam int COLV_W = 3;
  localparam int OUT_W  = 5;

  typedef struct packed {
    logic shiftEn;
    logic emitEn;
  } bgfStrobe_t;

  // vertical 1-2-1 weighted count of a 3-bit column code {top, mid, bottom}
  function automatic logic [COLV_W-1:0] colWeight(input logic [2:0] code);
    return {2'b00, code[2]} + {1'b0, code[1], 1'b0} + {2'b00, code[0]};
  endfunction
endpackage

// File: rtl/bgf_ctrl.sv
module bgf_ctrl
  import bgf_pkg::*;
#(
  parameter int IMG_W = 8,
  parameter int COL_W = $clog2(IMG_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pixValid,
  input  logic             lineStart,
  input  logic             frameStart,
  output bgfStrobe_t       strobe,
  output logic [COL_W-1:0] colIdx
);
  localparam logic [COL_W-1:0] COL_END = COL_W'(IMG_W);

  logic [COL_W-1:0] colCnt;
  logic [1:0]       rowCnt;
  logic [COL_W-1:0] curCol;
  logic [1:0]       curRow;
  logic             inRange;

  always_comb begin
    curCol = lineStart ? '0 : colCnt;
    if (frameStart)      curRow = 2'd0;
    else if (lineStart)  curRow = (rowCnt == 2'd2) ? 2'd2 : rowCnt + 2'd1;
    else                 curRow = rowCnt;
    inRange        = curCol < COL_END;
    strobe.shiftEn = pixValid && inRange;
    strobe.emitEn  = pixValid && inRange && (curRow == 2'd2) && (curCol >= COL_W'(2));
    colIdx         = curCol;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colCnt <= '0;
      rowCnt <= 2'd0;
    end else if (pixValid) begin
      rowCnt <= curRow;
      colCnt <= inRange ? curCol + COL_W'(1) : curCol;
    end
  end
endmodule

// File: rtl/bgf_datapath.sv
module bgf_datapath
  import bgf_pkg::*;
#(
  parameter int IMG_W    = 8,
  parameter int COL_W    = $clog2(IMG_W + 1),
  parameter int THR_INIT = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             thrWrEn,
  input  logic [PIX_W-1:0] thrWrData,
  input  logic [PIX_W-1:0] pixIn,
  input  bgfStrobe_t       strobe,
  input  logic [COL_W-1:0] colIdx,
  output logic             outValid,
  output logic [OUT_W-1:0] outPix
);
  localparam int AW = (IMG_W > 1) ? $clog2(IMG_W) : 1;

  logic [PIX_W-1:0]  thr;
  logic              pixBit;
  logic              lbMid [IMG_W];
  logic              lbTop [IMG_W];
  logic [AW-1:0]     idx;
  logic [2:0]        code;
  logic [COLV_W-1:0] lutTab [8];
  logic [COLV_W-1:0] colV0, colV1, colV2;
  logic              emitD;

  for (genvar gi = 0; gi < 8; gi++) begin : g_lut
    assign lutTab[gi] = colWeight(3'(gi));
  end

  assign idx    = colIdx[AW-1:0];
  assign pixBit = pixIn > thr;
  assign code   = {lbTop[idx], lbMid[idx], pixBit};

  always_ff @(posedge clk) begin
    if (!rstN) thr <= PIX_W'(THR_INIT);
    else if (thrWrEn) thr <= thrWrData;
  end

  always_ff @(posedge clk) begin
    if (strobe.shiftEn) begin
      lbTop[idx] <= lbMid[idx];
      lbMid[idx] <= pixBit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colV0    <= '0;
      colV1    <= '0;
      colV2    <= '0;
      emitD    <= 1'b0;
      outValid <= 1'b0;
      outPix   <= '0;
    end else begin
      if (strobe.shiftEn) begin
        colV0 <= lutTab[code];
        colV1 <= colV0;
        colV2 <= colV1;
      end
      emitD    <= strobe.emitEn;
      outValid <= emitD;
      if (emitD)
        outPix <= {2'b00, colV2} + {1'b0, colV1, 1'b0} + {2'b00, colV0};
    end
  end
endmodule

// File: rtl/bin_gauss_filter.sv
module bin_gauss_filter
  import bgf_pkg::*;
#(
  parameter int IMG_W    = 8,
  parameter int THR_INIT = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             thrWrEn,
  input  logic [7:0]       thrWrData,
  input  logic             pixValid,
  input  logic [7:0]       pixIn,
  input  logic             lineStart,
  input  logic             frameStart,
  output logic             outValid,
  output logic [4:0]       outPix
);
  localparam int COL_W = $clog2(IMG_W + 1);

  bgfStrobe_t       strobe;
  logic [COL_W-1:0] colIdx;

  bgf_ctrl #(.IMG_W(IMG_W), .COL_W(COL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .lineStart(lineStart),
    .frameStart(frameStart), .strobe(strobe), .colIdx(colIdx)
  );

  bgf_datapath #(.IMG_W(IMG_W), .COL_W(COL_W), .THR_INIT(THR_INIT)) u_dp (
    .clk(clk), .rstN(rstN), .thrWrEn(thrWrEn), .thrWrData(thrWrData),
    .pixIn(pixIn), .strobe(strobe), .colIdx(colIdx),
    .outValid(outValid), .outPix(outPix)
  );
endmodule

// File: rtl/bgf_checker.sv
module bgf_checker (
  input logic       clk,
  input logic       rstN,
  input logic       pixValid,
  input logic       lineStart,
  input logic       frameStart,
  input logic       outValid,
  input logic [4:0] outPix
);
  AST_OUT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outPix <= 5'd16); // R5
  AST_VALID_FROM_PIXEL: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(pixValid, 2)); // R6
  AST_NO_OUT_LINE_HEAD: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && lineStart) |-> ##2 !outValid); // R3
  AST_NO_OUT_FRAME_HEAD: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && frameStart) |-> ##2 !outValid); // R7
endmodule

bind bin_gauss_filter bgf_checker u_chk (
  .clk(clk), .rstN(rstN), .pixValid(pixValid), .lineStart(lineStart),
  .frameStart(frameStart), .outValid(outValid), .outPix(outPix)
);

// File: tb/bin_gauss_filter_tb.sv
module bin_gauss_filter_tb;
  localparam int W = 8;
  localparam int H = 6;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       thrWrEn = 1'b0;
  logic [7:0] thrWrData = 8'd0;
  logic       pixValid = 1'b0;
  logic [7:0] pixIn = 8'd0;
  logic       lineStart = 1'b0;
  logic       frameStart = 1'b0;
  logic       outValid;
  logic [4:0] outPix;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int img [H][W];
  int gotQ [$];

  always #5 clk = ~clk;

  bin_gauss_filter #(.IMG_W(W)) u_dut (
    .clk(clk), .rstN(rstN), .thrWrEn(thrWrEn), .thrWrData(thrWrData),
    .pixValid(pixValid), .pixIn(pixIn), .lineStart(lineStart),
    .frameStart(frameStart), .outValid(outValid), .outPix(outPix)
  );

  always @(negedge clk) if (rstN && outValid) gotQ.push_back(int'(outPix));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected 0", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic setThr(input int v);
    @(negedge clk);
    thrWrEn = 1'b1; thrWrData = 8'(v);
    @(negedge clk);
    thrWrEn = 1'b0;
  endtask

  // gapMode inserts idle cycles; latCheck isolates the last pixel and times its pulse (R6)
  task automatic sendFrame(input bit gapMode, input bit latCheck);
    gotQ.delete();
    for (int r = 0; r < H; r++) begin
      for (int c = 0; c < W; c++) begin
        if ((gapMode && ((r + c) % 3 == 0)) || (latCheck && r == H-1 && c == W-1)) begin
          @(negedge clk); pixValid = 1'b0;
          if (latCheck) begin @(negedge clk); @(negedge clk); end
        end
        @(negedge clk);
        pixValid = 1'b1; pixIn = 8'(img[r][c]);
        lineStart = (c == 0); frameStart = (r == 0 && c == 0);
      end
    end
    @(negedge clk);
    pixValid = 1'b0; lineStart = 1'b0; frameStart = 1'b0;
    if (latCheck) begin
      check(outValid == 1'b0, "R6 early", int'(outValid), 0);
      @(negedge clk);
      check(outValid == 1'b1, "R6 pulse", int'(outValid), 1);
      @(negedge clk);
      check(outValid == 1'b0, "R6 width", int'(outValid), 0);
    end
    repeat (4) @(negedge clk);
  endtask

  // reference: threshold (R1) then 1-2-1 x 1-2-1 window sum (R4), raster order (R8)
  task automatic checkFrame(input int thr, input string tag);
    int wt [3] = '{1, 2, 1};
    int n = 0;
    check(gotQ.size() == (H-2)*(W-2), {tag, " R3 count"}, gotQ.size(), (H-2)*(W-2));
    for (int r = 2; r < H; r++) begin
      for (int c = 2; c < W; c++) begin
        int exp = 0;
        for (int dr = 0; dr < 3; dr++)
          for (int dc = 0; dc < 3; dc++)
            exp += wt[dr] * wt[dc] * ((img[r-2+dr][c-2+dc] > thr) ? 1 : 0);
        if (n < gotQ.size())
          check(gotQ[n] == exp, {tag, " R4 R8 pixel"}, gotQ[n], exp);
        n++;
      end
    end
  endtask

  task automatic testReset();
    check(outValid == 1'b0, "R3 reset valid", int'(outValid), 0);
    check(outPix == 5'd0, "reset pixel", int'(outPix), 0);
  endtask

  task automatic testRandom();
    for (int r = 0; r < H; r++) for (int c = 0; c < W; c++) img[r][c] = $urandom_range(0, 255);
    sendFrame(1'b0, 1'b0);
    checkFrame(128, "random");
  endtask

  task automatic testWhiteBlack();
    for (int r = 0; r < H; r++) for (int c = 0; c < W; c++) img[r][c] = 255;
    sendFrame(1'b0, 1'b0);
    check(gotQ.size() > 0 && gotQ[0] == 16, "R5 white", gotQ.size() > 0 ? gotQ[0] : -1, 16);
    checkFrame(128, "white");
    for (int r = 0; r < H; r++) for (int c = 0; c < W; c++) img[r][c] = 0;
    sendFrame(1'b0, 1'b0);
    check(gotQ.size() > 0 && gotQ[0] == 0, "R5 black", gotQ.size() > 0 ? gotQ[0] : -1, 0);
    checkFrame(128, "black");
  endtask

  task automatic testChecker();
    for (int r = 0; r < H; r++) for (int c = 0; c < W; c++) img[r][c] = ((r + c) % 2) ? 255 : 0;
    sendFrame(1'b0, 1'b0);
    checkFrame(128, "checker");
  endtask

  task automatic testEqualThr();
    for (int r = 0; r < H; r++) for (int c = 0; c < W; c++) img[r][c] = 128;
    sendFrame(1'b0, 1'b0);
    check(gotQ.size() > 0 && gotQ[0] == 0, "R1 equal", gotQ.size() > 0 ? gotQ[0] : -1, 0);
    for (int r = 0; r < H; r++) for (int c = 0; c < W; c++) img[r][c] = (c < 4) ? 129 : 128;
    sendFrame(1'b0, 1'b0);
    checkFrame(128, "R1 edge");
  endtask

  task automatic testThrWrite();
    setThr(60);
    for (int r = 0; r < H; r++) for (int c = 0; c < W; c++) img[r][c] = (r == 3) ? 61 : 60;
    sendFrame(1'b0, 1'b0);
    checkFrame(60, "R2 thr60");
    setThr(128);
  endtask

  task automatic testGaps();
    for (int r = 0; r < H; r++) for (int c = 0; c < W; c++) img[r][c] = $urandom_range(100, 160);
    sendFrame(1'b1, 1'b0);
    checkFrame(128, "R7 gaps");
    sendFrame(1'b0, 1'b1);
    checkFrame(128, "R6 isolated");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testRandom();
    testWhiteBlack();
    testChecker();
    testEqualThr();
    testThrWrite();
    testGaps();
    testRandom();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule